// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

The block is one channel of a DMA engine. It copies elements of 1, 2, 4 or 8 bytes from a source address range to a destination address range through a memory port with separate read and write handshakes. Software programs five write-only registers through a plain write strobe. Address 0 holds the source base, 1 the destination base, 2 the element count, 3 the circular queue length in bytes, and 4 the control word. Each address can either advance by the element size after every element or stay fixed. With circular mode enabled, an advancing address returns to its base once its offset reaches the queue length.

A request is started in one of three ways: a peripheral request pulse, a start bit written in the control word, or a pulse from another channel's completion. In block mode one request copies every element. In single-value mode each request copies one element, and the sequence resumes at the next request. Completion is reported by a sticky done flag and by a one-cycle pulse that can start a following channel. An optional interrupt pulse follows each element in single-value mode, or each finished block in block mode. A misaligned address or a zero count at the start of a sequence raises an error flag and no memory traffic is issued.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, busy, done, err, irq, link_out, rd_valid and wr_valid are all low.
- R2: Control bits [1:0] select the element size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). rd_size and wr_size carry this code. wr_data holds the low bytes of the read response for that size, and its upper bits are zero.
- R3: Control bit 2 makes the source address advance by the element size after each element, and control bit 3 does the same for the destination. With the bit clear, that address stays at its base.
- R4: With control bit 4 set (block mode), one request copies all programmed elements back to back.
- R5: With control bit 4 clear (single-value mode), each request copies exactly one element. The addresses and the remaining count carry over to the next request.
- R6: A request is started by a one-cycle pulse on periph_req, a one-cycle pulse on link_in, or a write to the control word with bit 7 set. Bit 7 is not stored.
- R7: With control bit 6 set, an advancing address offset returns to zero when it would reach the queue length held in register 3.
- R8: When control bit 5 is set, irq pulses for one cycle after every element in single-value mode and after the last element in block mode. With bit 5 clear, irq stays low. On the last element of a sequence, done is set and link_out pulses once, whatever bit 5 holds.
- R9: At the start of a new sequence, a source or destination base that is not a multiple of the element size, or a count of zero, sets err and issues no read. A control-word write clears err.
- R10: busy is high from the accepted request until the last write of that request is accepted. Any number of requests that arrive while busy are kept as one pending request, which starts once busy drops.
- R11: At most one read is outstanding, and each write follows its read. A read or write request holds its valid, address and data steady until ready is seen, and rd_valid and wr_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | AW | Register write data |
| periph_req | input | 1 | Peripheral request pulse |
| link_in | input | 1 | Completion pulse from another channel |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rd_size | output | 2 | Read element size code |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Read data, element in the low bytes |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 64 | Write data, element in the low bytes |
| wr_size | output | 2 | Write element size code |
| busy | output | 1 | Request in progress |
| done | output | 1 | Sequence finished (sticky) |
| err | output | 1 | Configuration rejected (sticky) |
| irq | output | 1 | Interrupt pulse |
| link_out | output | 1 | Completion pulse for a following channel |

## Verification
A wrong offset counter shows up on rd_addr or wr_addr at the next element, one to three cycles after the previous write is accepted. A wrapped circular queue shows it as a repeated address at the queue boundary. A wrong remaining count changes the number of writes and moves the done and link_out pulses, which the bench sees by the end of the request. A wrong pending or launch state shows up as an extra or missing burst of reads once busy drops. A wrong size mask shows up as stray upper bytes on wr_data in the same cycle that wr_valid rises.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          periph_req,
  input  logic          link_in,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic          rsp_valid,
  input  logic [63:0]   rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic [1:0]    wr_size,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq,
  output logic          link_out
);
  localparam int DW = 64;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src_base, dst_base, src_off, dst_off, bytes;
  logic [CW-1:0] cnt_cfg, qlen, remain;
  logic [1:0]    size_q;
  logic          src_inc, dst_inc, blk, irq_en, circ, pend, seen;
  logic [DW-1:0] data_q, mask;

  assign bytes    = AW'(1) << size_q;
  assign rd_addr  = src_base + src_off;
  assign wr_addr  = dst_base + dst_off;
  assign rd_size  = size_q;
  assign wr_size  = size_q;
  assign wr_data  = data_q;
  assign rd_valid = (st == S_RD);
  assign wr_valid = (st == S_WR);
  assign busy     = (st != S_IDLE);

  always_comb begin
    case (size_q)
      2'd0:    mask = DW'(64'h0000_0000_0000_00ff);
      2'd1:    mask = DW'(64'h0000_0000_0000_ffff);
      2'd2:    mask = DW'(64'h0000_0000_ffff_ffff);
      default: mask = '1;
    endcase
  end

  logic ctl_wr, sw_start, go, fresh, bad, last;
  assign ctl_wr   = cfg_we && (cfg_addr == 3'd4);
  assign sw_start = ctl_wr && cfg_wdata[7];
  assign go       = (st == S_IDLE) && (pend || periph_req || link_in);
  assign fresh    = (remain == '0);
  assign bad      = (cnt_cfg == '0) || (|((src_base | dst_base) & (bytes - AW'(1))));
  assign last     = (remain == CW'(1));

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] off, input logic inc);
    logic [AW-1:0] s;
    s = off + bytes;
    if (!inc)                    return off;
    if (circ && (s >= AW'(qlen))) return '0;
    return s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_base <= '0; dst_base <= '0; cnt_cfg <= '0; qlen <= '0;
      size_q <= '0; src_inc <= 1'b0; dst_inc <= 1'b0; blk <= 1'b0;
      irq_en <= 1'b0; circ <= 1'b0;
      src_off <= '0; dst_off <= '0; remain <= '0; data_q <= '0;
      pend <= 1'b0; done <= 1'b0; err <= 1'b0; irq <= 1'b0; link_out <= 1'b0;
      seen <= 1'b0;
    end else begin
      seen     <= 1'b1;
      irq      <= 1'b0;
      link_out <= 1'b0;

      if (cfg_we && !busy) begin
        case (cfg_addr)
          3'd0: src_base <= cfg_wdata;
          3'd1: dst_base <= cfg_wdata;
          3'd2: cnt_cfg  <= cfg_wdata[CW-1:0];
          3'd3: qlen     <= cfg_wdata[CW-1:0];
          3'd4: begin
            size_q  <= cfg_wdata[1:0];
            src_inc <= cfg_wdata[2];
            dst_inc <= cfg_wdata[3];
            blk     <= cfg_wdata[4];
            irq_en  <= cfg_wdata[5];
            circ    <= cfg_wdata[6];
            err     <= 1'b0;
          end
          default: ;
        endcase
      end

      if (go) pend <= 1'b0;
      if (sw_start || (busy && (periph_req || link_in))) pend <= 1'b1;

      case (st)
        S_IDLE: if (go) begin
          if (fresh && bad) begin
            err <= 1'b1;
          end else begin
            if (fresh) begin
              remain  <= cnt_cfg;
              src_off <= '0;
              dst_off <= '0;
              done    <= 1'b0;
            end
            st <= S_RD;
          end
        end
        S_RD:   if (rd_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          data_q <= rsp_data & mask;
          st     <= S_WR;
        end
        S_WR:   if (wr_ready) begin
          remain  <= remain - CW'(1);
          src_off <= advance(src_off, src_inc);
          dst_off <= advance(dst_off, dst_inc);
          if (last) begin
            done     <= 1'b1;
            link_out <= 1'b1;
            irq      <= irq_en;
            st       <= S_IDLE;
          end else if (blk) begin
            st <= S_RD;
          end else begin
            irq <= irq_en;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_hold_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_addr & (bytes - AW'(1))) == '0));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(busy)) |-> $past(wr_valid && wr_ready));

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(err)) |-> !busy);
endmodule

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        periph_req = 1'b0, link_in = 1'b0;
  logic        rd_valid, rd_ready = 1'b1, rsp_valid = 1'b0;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_size, wr_size;
  logic [63:0] rsp_data = '0, wr_data;
  logic        wr_valid, wr_ready = 1'b1;
  logic        busy, done, err, irq, link_out;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .periph_req(periph_req), .link_in(link_in),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
    .busy(busy), .done(done), .err(err), .irq(irq), .link_out(link_out));

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {~a, a};
  endfunction

  function automatic logic [63:0] msk(input int sz);
    return (sz == 3) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [31:0] ctl(input int sz, input bit si, input bit di, input bit bk,
                                      input bit ie, input bit cq, input bit st);
    return {24'd0, st, cq, ie, bk, di, si, 2'(sz)};
  endfunction

  logic [31:0] ra [0:63];
  logic [31:0] wa [0:63];
  logic [63:0] wd [0:63];
  logic [1:0]  ws [0:63];
  logic [1:0]  rs [0:63];
  int nr = 0, nw = 0, nirq = 0, nlink = 0, outst = 0, ovf = 0;
  logic        acc = 1'b0;
  logic [31:0] acc_a = '0;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (acc) begin
      rsp_valid = 1'b1;
      rsp_data  = pat(acc_a);
      acc = 1'b0;
    end
    if (rd_valid && rd_ready) begin
      acc = 1'b1; acc_a = rd_addr;
      if (nr < 64) begin ra[nr] = rd_addr; rs[nr] = rd_size; end
      nr++; outst++;
      if (outst > 1) ovf++;
    end
    if (wr_valid && wr_ready) begin
      if (nw < 64) begin wa[nw] = wr_addr; wd[nw] = wr_data; ws[nw] = wr_size; end
      nw++; outst--;
    end
    if (irq) nirq++;
    if (link_out) nlink++;
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cw(input logic [2:0] a, input logic [31:0] d);
    cyc(1);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_periph();
    cyc(1); periph_req = 1'b1; cyc(1); periph_req = 1'b0;
  endtask

  task automatic pulse_link();
    cyc(1); link_in = 1'b1; cyc(1); link_in = 1'b0;
  endtask

  task automatic wait_idle();
    cyc(4);
    for (int i = 0; i < 2000 && busy; i++) cyc(1);
    cyc(3);
  endtask

  task automatic clr();
    nr = 0; nw = 0; nirq = 0; nlink = 0; ovf = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 link_out", link_out, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_valid", wr_valid, 0);
  endtask

  task automatic t_block();
    clr();
    cw(0, 32'h100); cw(1, 32'h200); cw(2, 4);
    cw(4, ctl(2, 1, 1, 1, 1, 0, 1));
    wait_idle();
    chk("R4 write count", nw, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 dst advance", wa[i], 32'h200 + 4 * i);
      chk("R2 data 4B", wd[i], pat(32'h100 + 4 * i) & msk(2));
      chk("R2 wr_size", ws[i], 2);
    end
    chk("R8 irq once", nirq, 1);
    chk("R8 link once", nlink, 1);
    chk("R8 done", done, 1);
  endtask

  task automatic t_hold();
    clr();
    cw(0, 32'h13); cw(1, 32'h40); cw(2, 3);
    cw(4, ctl(0, 0, 1, 1, 0, 0, 1));
    wait_idle();
    chk("R3 count", nw, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 src held", ra[i], 32'h13);
      chk("R3 dst byte step", wa[i], 32'h40 + i);
      chk("R2 byte mask", wd[i], 64'hec13 & 64'hff);
      chk("R2 rd_size", rs[i], 0);
    end
  endtask

  task automatic t_single();
    clr();
    cw(0, 32'h800); cw(1, 32'h900); cw(2, 3);
    cw(4, ctl(3, 1, 1, 0, 1, 0, 0));
    pulse_periph();
    wait_idle();
    chk("R5 one element per periph_req", nw, 1);
    chk("R8 irq per element", nirq, 1);
    chk("R8 no link mid-sequence", nlink, 0);
    chk("R5 done low mid-sequence", done, 0);
    pulse_link();
    wait_idle();
    chk("R6 link_in trigger", nw, 2);
    chk("R5 continues address", wa[1], 32'h908);
    cw(4, ctl(3, 1, 1, 0, 1, 0, 1));
    wait_idle();
    chk("R6 software start", nw, 3);
    chk("R5 third address", ra[2], 32'h810);
    chk("R2 8B data", wd[2], pat(32'h810));
    chk("R8 irq count single", nirq, 3);
    chk("R8 link at end", nlink, 1);
    chk("R8 done at end", done, 1);
  endtask

  task automatic t_circ();
    clr();
    cw(0, 32'h1000); cw(1, 32'h2000); cw(2, 5); cw(3, 6);
    cw(4, ctl(1, 1, 0, 1, 0, 1, 1));
    wait_idle();
    chk("R7 count", nw, 5);
    chk("R7 addr0", ra[0], 32'h1000);
    chk("R7 addr2", ra[2], 32'h1004);
    chk("R7 wrap", ra[3], 32'h1000);
    chk("R7 after wrap", ra[4], 32'h1002);
    chk("R3 dst hold", wa[4], 32'h2000);
    chk("R2 2B data", wd[3], pat(32'h1000) & msk(1));
  endtask

  task automatic t_irq_off();
    clr();
    cw(0, 32'h0); cw(1, 32'h80); cw(2, 2);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    wait_idle();
    chk("R8 irq masked", nirq, 0);
    chk("R8 link unmasked", nlink, 1);
    chk("R8 done unmasked", done, 1);
  endtask

  task automatic t_err();
    clr();
    cw(0, 32'h102); cw(1, 32'h300); cw(2, 2);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    cyc(6);
    chk("R9 misaligned err", err, 1);
    chk("R9 no read", nr, 0);
    chk("R9 not busy", busy, 0);
    cw(0, 32'h100);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 0));
    chk("R9 err cleared", err, 0);
    cw(2, 0);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    cyc(6);
    chk("R9 zero count err", err, 1);
    chk("R9 no read zero count", nr, 0);
    cw(2, 2);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    wait_idle();
    chk("R9 runs after fix", nw, 2);
    chk("R9 err low after fix", err, 0);
  endtask

  task automatic t_pending();
    clr();
    cw(0, 32'h400); cw(1, 32'h500); cw(2, 4);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    cyc(3);
    chk("R10 busy during request", busy, 1);
    pulse_periph();
    pulse_periph();
    pulse_link();
    wait_idle();
    cyc(3);
    wait_idle();
    chk("R10 one pending run", nw, 8);
    chk("R10 pending reads", nr, 8);
    chk("R10 idle at end", busy, 0);
    chk("R10 second run restarts", wa[4], 32'h500);
  endtask

  task automatic t_stall();
    clr();
    rd_ready = 1'b0; wr_ready = 1'b0;
    cw(0, 32'h600); cw(1, 32'h700); cw(2, 2);
    cw(4, ctl(2, 1, 1, 1, 0, 0, 1));
    cyc(5);
    chk("R11 rd_valid held", rd_valid, 1);
    chk("R11 rd_addr held", rd_addr, 32'h600);
    chk("R11 no read before ready", nr, 0);
    rd_ready = 1'b1;
    cyc(5);
    chk("R11 wr_valid held", wr_valid, 1);
    chk("R11 wr_addr held", wr_addr, 32'h700);
    chk("R11 wr_data held", wr_data, pat(32'h600) & msk(2));
    chk("R11 no second read", nr, 1);
    wr_ready = 1'b1;
    wait_idle();
    chk("R11 writes", nw, 2);
    chk("R11 outstanding limit", ovf, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_block();
    t_hold();
    t_single();
    t_circ();
    t_irq_off();
    t_err();
    t_pending();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule